// File: doc/BRIEF.md
# S/PDIF Channel Status Formatter

This block keeps the 16-bit control word that governs an S/PDIF transmitter. For every subframe it turns that word into the validity (V) and channel status (C) bits, and it clears the upper audio bits when the stream is flagged invalid. It sits between the sample source and the serializer. The serializer does the line coding, preambles and parity. This block only supplies the per-subframe V bit, C bit and data word.

Software writes the control word through a simple write port and can read it back at any time. While the transmitter is running, only the validity-force bit can be changed. Every other field is frozen, so a block of channel status never carries a mix of old and new settings. The C bits are sent one per frame across a 192-frame block, and both subframes of a frame carry the same bit. The frame position restarts whenever the transmitter is switched off. The status fields are captured on the first subframe of each block.

Top module: `spdif_cs_fmt`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0x2000. This is sample-rate code 2'b10 (48 kHz) in bits 13:12, with every other field 0.
- R2: Bit 14 of `rd_data` (the double-rate flag) always reads 0, whatever is written.
- R3: Bit 0 of `rd_data` (professional format) is read-only and always reads 0.
- R4: A write (`wr_en`=1) always updates bit 15. Bits 13:1 are updated only when `tx_enable` is 0 in that cycle; otherwise they keep their value.
- R5: With bit 15 = 0, `v_bit` equals the `underrun` input that came with the subframe. With bit 15 = 1, `v_bit` is 1.
- R6: With bit 15 = 1, `data_out[23:4]` (subframe slots 8 to 27) is 0 and `data_out[3:0]` passes `sample[3:0]`. With bit 15 = 0, `data_out` equals `sample`.
- R7: One cycle after each `sf_stb` pulse, `out_vld` is 1 for exactly one cycle, and it carries the results for that subframe.
- R8: `c_bit` is the channel status bit whose index is the current frame number. A frame ends with the subframe where `sf_chan`=1. The frame number steps by one at each frame end while enabled and returns to 0 after frame 191.
- R9: While `tx_enable` is 0, the frame number is held at 0. After re-enabling, the next frame is frame 0.
- R10: The channel status layout is:
  - bit 0: professional format flag (register bit 0)
  - bit 1: non-audio (register bit 1)
  - bit 2: copyright (register bit 2; 1 means not asserted)
  - bit 3: emphasis, set by register bit 3; bits 4 and 5 are 0
  - bits 8 to 14: category code, register bits 4 to 10, lowest bit first
  - bit 15: generation level (register bit 11)
  - every other index: 0
- R11: Channel status bits 24 to 27 (frequency) follow the rate code in register bits 13:12:
  - 2'b00 gives 0000
  - 2'b10 gives bit 25 set
  - 2'b11 gives bits 24 and 25 set
  - the reserved code 2'b01 gives 0000

Bits 24 to 27 are listed in sending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write value |
| tx_enable | input | 1 | Transmitter running flag |
| underrun | input | 1 | Sample source ran dry for this subframe |
| sf_stb | input | 1 | One-cycle subframe strobe |
| sf_chan | input | 1 | 0 = first subframe of a frame, 1 = second |
| sample | input | 24 | Audio word, bit k goes to subframe slot k+4 |
| out_vld | output | 1 | Results below are valid |
| v_bit | output | 1 | Validity bit for the subframe |
| c_bit | output | 1 | Channel status bit for the subframe |
| data_out | output | 24 | Audio word after validity masking |
| rd_data | output | 16 | Control word readback |

## Verification
The bench runs more than a full 192-frame block, so a counter that wraps at the wrong count or never returns to 0 shifts every later C bit. It switches the transmitter off in the middle of a block and checks that the next block restarts at frame 0; a counter that is not cleared would resume mid-block. It writes all ones and mixed values with the transmitter both on and off. A lock that also freezes bit 15, or that lets the lower fields through, shows up in the readback. The force mode uses all-ones samples and every rate code, including the reserved one, so a mask placed at the wrong slot or a wrong frequency mapping changes `data_out` or the C bits at indices 24 and 25.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;

  localparam int CTL_W = 16;
  localparam logic [CTL_W-1:0] CTL_RESET = 16'h2000;

  // control word field positions
  localparam int VF_BIT   = 15;
  localparam int DR_BIT   = 14;
  localparam int RATE_HI  = 13;
  localparam int RATE_LO  = 12;
  localparam int GEN_BIT  = 11;
  localparam int CAT_HI   = 10;
  localparam int CAT_LO   = 4;
  localparam int EMPH_BIT = 3;
  localparam int COPY_BIT = 2;
  localparam int NAUD_BIT = 1;
  localparam int PRO_BIT  = 0;

  // channel status positions
  localparam int CSI_CAT_LO = 8;
  localparam int CSI_CAT_HI = 14;
  localparam int CSI_GEN    = 15;
  localparam int CSI_FS_LO  = 24;
  localparam int CSI_FS_HI  = 27;

  typedef struct packed {
    logic       pro;
    logic       naud;
    logic       copy_n;
    logic       emph;
    logic [6:0] cat;
    logic       gen;
    logic [3:0] fs;   // fs[0] is sent first (status index 24)
  } cs_fields_t;

  function automatic logic [3:0] rate_to_fs(input logic [1:0] code);
    logic [3:0] f;
    case (code)
      2'b10:   f = 4'b0010;
      2'b11:   f = 4'b0011;
      default: f = 4'b0000;
    endcase
    return f;
  endfunction

  function automatic cs_fields_t decode_ctl(input logic [CTL_W-1:0] c);
    cs_fields_t f;
    f.pro    = c[PRO_BIT];
    f.naud   = c[NAUD_BIT];
    f.copy_n = c[COPY_BIT];
    f.emph   = c[EMPH_BIT];
    f.cat    = c[CAT_HI:CAT_LO];
    f.gen    = c[GEN_BIT];
    f.fs     = rate_to_fs(c[RATE_HI:RATE_LO]);
    return f;
  endfunction

  function automatic logic cs_bit_at(input cs_fields_t f, input logic [7:0] idx);
    logic b;
    b = 1'b0;
    if (idx == 8'd0)
      b = f.pro;
    else if (idx == 8'd1)
      b = f.naud;
    else if (idx == 8'd2)
      b = f.copy_n;
    else if (idx == 8'd3)
      b = f.emph;
    else if (idx >= 8'(CSI_CAT_LO) && idx <= 8'(CSI_CAT_HI))
      b = f.cat[3'(idx - 8'(CSI_CAT_LO))];
    else if (idx == 8'(CSI_GEN))
      b = f.gen;
    else if (idx >= 8'(CSI_FS_LO) && idx <= 8'(CSI_FS_HI))
      b = f.fs[2'(idx - 8'(CSI_FS_LO))];
    return b;
  endfunction

endpackage

// File: rtl/cs_ctrl_reg.sv
module cs_ctrl_reg
  import spdif_cs_pkg::*;
#(
  parameter int              W       = CTL_W,
  parameter logic [W-1:0]    RST_VAL = CTL_RESET
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         tx_enable,
  output logic [W-1:0] ctl_q
);

  // bits writable while running: only the validity force
  localparam logic [W-1:0] RUN_MASK = W'(1) << VF_BIT;
  // bits that never take a written value
  localparam logic [W-1:0] RO_MASK  = (W'(1) << DR_BIT) | (W'(1) << PRO_BIT);

  logic [W-1:0] wmask;

  always_comb begin
    wmask = tx_enable ? RUN_MASK : {W{1'b1}};
    wmask = wmask & ~RO_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= RST_VAL & ~RO_MASK;
    else if (wr_en)
      ctl_q <= (ctl_q & ~wmask) | (wr_data & wmask);
  end

endmodule

// File: rtl/cs_block_seq.sv
module cs_block_seq
  import spdif_cs_pkg::*;
#(
  parameter int FRAMES = 192,
  parameter int IDX_W  = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_enable,
  input  logic             sf_stb,
  input  logic             sf_chan,
  input  logic [CTL_W-1:0] ctl,
  output logic [IDX_W-1:0] idx_o,
  output cs_fields_t       fields_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  logic [IDX_W-1:0] idx_q;
  cs_fields_t       lat_q;
  cs_fields_t       live;
  logic             take_new;
  logic             frame_end;

  assign live      = decode_ctl(ctl);
  assign take_new  = sf_stb && !sf_chan && (idx_q == '0);
  assign frame_end = sf_stb && sf_chan && tx_enable;

  always_ff @(posedge clk) begin
    if (rst || !tx_enable)
      idx_q <= '0;
    else if (frame_end)
      idx_q <= (idx_q == LAST) ? '0 : idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)
      lat_q <= decode_ctl(CTL_RESET);
    else if (take_new)
      lat_q <= live;
  end

  // the first subframe of a block uses the live word, which is being latched now
  assign fields_o = take_new ? live : lat_q;
  assign idx_o    = idx_q;

endmodule

// File: rtl/cs_sub_fmt.sv
module cs_sub_fmt
  import spdif_cs_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int KEEP_LSBS = 4,
  parameter int IDX_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sf_stb,
  input  logic              underrun,
  input  logic              force_v,
  input  logic [DATA_W-1:0] sample,
  input  cs_fields_t        fields,
  input  logic [IDX_W-1:0]  idx,
  output logic              out_vld,
  output logic              v_bit,
  output logic              c_bit,
  output logic [DATA_W-1:0] data_out
);

  logic [DATA_W-1:0] masked;

  // per-bit gating: low slots always pass, upper slots cleared when forced
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    if (g < KEEP_LSBS) begin : g_keep
      assign masked[g] = sample[g];
    end else begin : g_gate
      assign masked[g] = sample[g] & ~force_v;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      v_bit    <= 1'b0;
      c_bit    <= 1'b0;
      data_out <= '0;
    end else begin
      out_vld <= sf_stb;
      if (sf_stb) begin
        v_bit    <= force_v | underrun;
        c_bit    <= cs_bit_at(fields, 8'(idx));
        data_out <= masked;
      end
    end
  end

endmodule

// File: rtl/spdif_cs_fmt.sv
module spdif_cs_fmt
  import spdif_cs_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int KEEP_LSBS = 4,
  parameter int FRAMES    = 192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              tx_enable,
  input  logic              underrun,
  input  logic              sf_stb,
  input  logic              sf_chan,
  input  logic [DATA_W-1:0] sample,
  output logic              out_vld,
  output logic              v_bit,
  output logic              c_bit,
  output logic [DATA_W-1:0] data_out,
  output logic [15:0]       rd_data
);

  localparam int IDX_W = $clog2(FRAMES);

  logic [CTL_W-1:0] ctl;
  logic [IDX_W-1:0] idx;
  cs_fields_t       fields;

  cs_ctrl_reg #(.W(CTL_W), .RST_VAL(CTL_RESET)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tx_enable (tx_enable),
    .ctl_q     (ctl)
  );

  cs_block_seq #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tx_enable (tx_enable),
    .sf_stb    (sf_stb),
    .sf_chan   (sf_chan),
    .ctl       (ctl),
    .idx_o     (idx),
    .fields_o  (fields)
  );

  cs_sub_fmt #(.DATA_W(DATA_W), .KEEP_LSBS(KEEP_LSBS), .IDX_W(IDX_W)) u_fmt (
    .clk      (clk),
    .rst      (rst),
    .sf_stb   (sf_stb),
    .underrun (underrun),
    .force_v  (ctl[VF_BIT]),
    .sample   (sample),
    .fields   (fields),
    .idx      (idx),
    .out_vld  (out_vld),
    .v_bit    (v_bit),
    .c_bit    (c_bit),
    .data_out (data_out)
  );

  assign rd_data = ctl;

endmodule

// File: rtl/spdif_cs_fmt_chk.sv
module spdif_cs_fmt_chk #(
  parameter int DATA_W    = 24,
  parameter int KEEP_LSBS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              tx_enable,
  input logic              underrun,
  input logic              sf_stb,
  input logic              out_vld,
  input logic              v_bit,
  input logic [DATA_W-1:0] data_out,
  input logic [15:0]       rd_data
);

  assert_dr_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rd_data[14] == 1'b0);

  assert_pro_ro_R3: assert property (@(posedge clk) disable iff (rst)
    rd_data[0] == 1'b0);

  assert_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && tx_enable) |=> $stable(rd_data[13:0]));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr_en) |=> $stable(rd_data));

  assert_vforce_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && sf_stb && rd_data[15]) |=> v_bit);

  assert_vfollow_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && sf_stb && !rd_data[15]) |=> (v_bit == $past(underrun)));

  assert_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && sf_stb && rd_data[15]) |=> (data_out[DATA_W-1:KEEP_LSBS] == '0));

  assert_vld_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && sf_stb) |=> out_vld);

  assert_novld_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && !sf_stb) |=> !out_vld);

endmodule

bind spdif_cs_fmt spdif_cs_fmt_chk #(.DATA_W(DATA_W), .KEEP_LSBS(KEEP_LSBS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .tx_enable (tx_enable),
  .underrun  (underrun),
  .sf_stb    (sf_stb),
  .out_vld   (out_vld),
  .v_bit     (v_bit),
  .data_out  (data_out),
  .rd_data   (rd_data)
);

// File: tb/sim_spdif_cs_fmt.sv
`timescale 1ns/1ps
module sim_spdif_cs_fmt;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tx_enable = 1'b0;
  logic        underrun = 1'b0;
  logic        sf_stb = 1'b0;
  logic        sf_chan = 1'b0;
  logic [23:0] sample = '0;
  logic        out_vld, v_bit, c_bit;
  logic [23:0] data_out;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  spdif_cs_fmt u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .underrun(underrun), .sf_stb(sf_stb),
    .sf_chan(sf_chan), .sample(sample), .out_vld(out_vld),
    .v_bit(v_bit), .c_bit(c_bit), .data_out(data_out), .rd_data(rd_data)
  );

  int checks = 0;
  int failures = 0;
  logic [15:0] mreg = 16'h2000;
  int          midx = 0;
  logic        mtx = 1'b0;
  logic [25:0] expq[$];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // expected channel status bit, built from the requirement tables R10 and R11
  function automatic logic cs_exp(input logic [15:0] r, input int i);
    case (i)
      0:  return r[0];
      1:  return r[1];
      2:  return r[2];
      3:  return r[3];
      15: return r[11];
      24: return r[13] & r[12];
      25: return r[13];
      default: begin
        if (i >= 8 && i <= 14) return r[i-4];
        return 1'b0;
      end
    endcase
  endfunction

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    mreg[15] = d[15];
    if (!mtx) mreg[13:1] = d[13:1];
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 readback", 32'(rd_data), 32'(mreg));
  endtask

  task automatic set_tx(input logic v);
    @(negedge clk);
    tx_enable = v; mtx = v;
    if (!v) midx = 0;   // R9
  endtask

  // driver: pushes the expected subframe result
  task automatic sf(input logic chan, input logic und, input logic [23:0] smp);
    logic [23:0] ed;
    @(negedge clk);
    sf_stb = 1'b1; sf_chan = chan; underrun = und; sample = smp;
    ed = mreg[15] ? {20'd0, smp[3:0]} : smp;
    expq.push_back({mreg[15] | und, cs_exp(mreg, mtx ? midx : 0), ed});
    if (chan && mtx) midx = (midx == 191) ? 0 : midx + 1;
    @(negedge clk);
    sf_stb = 1'b0; underrun = 1'b0;
  endtask

  task automatic frames(input int n, input logic [23:0] base);
    for (int k = 0; k < n; k++) begin
      sf(1'b0, (k % 3) == 0, base ^ 24'(k * 37));
      sf(1'b1, (k % 5) == 1, ~base ^ 24'(k));
    end
  endtask

  // monitor: pops and compares
  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (expq.size() == 0) begin
        chk("R7 unexpected out_vld", 32'd1, 32'd0);
      end else begin
        logic [25:0] e;
        e = expq.pop_front();
        chk("R5 v_bit", 32'(v_bit), 32'(e[25]));
        chk("R8 R10 R11 c_bit", 32'(c_bit), 32'(e[24]));
        chk("R6 data_out", 32'(data_out), 32'(e[23:0]));
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog R7 got=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset value", 32'(rd_data), 32'h2000);
    chk("R7 no output after reset", 32'(out_vld), 32'd0);

    // disabled: all fields writable except read-only bits
    wr(16'hFFFF);
    chk("R2 bit14 zero", 32'(rd_data[14]), 32'd0);
    chk("R3 bit0 zero", 32'(rd_data[0]), 32'd0);
    chk("R4 open write", 32'(rd_data), 32'hBFFE);
    wr(16'h2D5C);

    // enabled: only bit 15 moves
    set_tx(1'b1);
    wr(16'h9234);
    chk("R4 locked", 32'(rd_data), 32'hAD5C);
    wr(16'h0001);
    chk("R4 bit15 cleared", 32'(rd_data), 32'h2D5C);

    // pulse timing
    sf(1'b0, 1'b1, 24'h123456);
    chk("R7 out_vld high", 32'(out_vld), 32'd1);
    @(negedge clk);
    chk("R7 out_vld one cycle", 32'(out_vld), 32'd0);
    sf(1'b1, 1'b0, 24'h654321);

    // more than a block: wrap after frame 191 (R8)
    frames(193, 24'hA5C3F0);

    // forced validity and masking
    wr(16'h8000);
    for (int k = 0; k < 4; k++) begin
      sf(1'b0, 1'b0, 24'hFFFFFF);
      sf(1'b1, 1'b1, 24'hF0F0F7);
    end
    wr(16'h0000);

    // mid-block stop: counter held at 0, restart at frame 0 (R9)
    frames(5, 24'h0F1E2D);
    set_tx(1'b0);
    frames(3, 24'h333333);
    set_tx(1'b1);
    frames(20, 24'h777777);

    // rate codes 11, 00 and reserved 01 (R11)
    set_tx(1'b0);
    wr(16'h3A32);
    set_tx(1'b1);
    frames(30, 24'h13579B);
    set_tx(1'b0);
    wr(16'h0AB6);
    set_tx(1'b1);
    frames(30, 24'h2468AC);
    set_tx(1'b0);
    wr(16'h1FFE);
    set_tx(1'b1);
    frames(30, 24'hFEDCBA);

    repeat (3) @(negedge clk);
    chk("R7 all results seen", 32'(expq.size()), 32'd0);
    finish_run();
  end

endmodule